// File: doc/BRIEF.md
# I/Q Sample Bridge with Time-Division Multiplexing

This block connects the output ports of a digital down-converter to the input ports of a digital up-converter and carries complex baseband samples between them. Each side has four sample lanes, A to D. In the parallel form, every sample word crosses through two register stages. The lanes are swapped in pairs: the down-converter's C and D feed the up-converter's A and B, and its A and B feed C and D. A sync pulse travels through the same two stages, so it stays aligned with the data.

A configuration input selects split-IQ operation (two channels, I and Q as parallel words) or four-channel operation (I then Q interleaved on each lane). A second input selects the time-division multiplexed form. In that form a serial stream enters on down-converter lane D and leaves on up-converter lane A. The frame holds four slots in split-IQ operation and eight in four-channel operation. Slots are ordered Q before I, highest channel first. The bridge collects a whole frame, realigning to a frame-start strobe. It then replays the frame in consecutive cycles with a regenerated frame marker, and the frame's sync flag rides on its first slot.

Any change of configuration flushes the block. No output is marked valid until a frame-start strobe has been accepted again.

Top module: `iq_tdm_bridge`

## Requirements
- R1: With tdm_i=0, output lane p carries input lane p XOR 2. Lane index 0 is A, 1 is B, 2 is C and 3 is D, and lane p occupies bits [p*DW +: DW].
- R2: With tdm_i=0, a sample taken at one clock edge appears on the outputs after the following edge. dn_sync_i is delayed by the same two edges whether or not the sample is valid.
- R3: With tdm_i=1, the serial stream is taken only from input lane 3 (D) and driven only on output lane 0 (A). Output lanes 1 to 3 read zero, and input lanes 0 to 2 have no effect.
- R4: With tdm_i=1, a frame holds 4 slots when mode_i=0 and 8 slots when mode_i=1. The first slot of a frame is on the outputs after the clock edge that follows the edge sampling its last slot. The remaining slots follow on consecutive cycles in arrival order, with up_valid_o high only for those slots.
- R5: With tdm_i=1, up_frame_o is high only with the first slot of a frame, and up_q_phase_o is high on even slot numbers (the Q slots). up_sync_o repeats the dn_sync_i value sampled with slot 0 and shows it only alongside slot 0. Sync on any other slot is ignored.
- R6: With tdm_i=1, a strobe on dn_frame_i (with dn_valid_i) restarts the slot count at 0, and a partly collected frame is discarded. Once aligned, further valid slots wrap into new frames without a strobe.
- R7: With tdm_i=0 and mode_i=1, up_q_phase_o is 0 on the first valid sample after a frame strobe and toggles on every later valid sample. With mode_i=0 it is 0.
- R8: After reset, and after any cycle in which mode_i or tdm_i differs from its value at the previous edge, up_valid_o is low from the next edge. It stays low until a strobe on dn_frame_i with dn_valid_i has been taken. Such a change also drops any frame being collected or replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 split-IQ (two channels), 1 four-channel |
| tdm_i | input | 1 | 1 selects the serial TDM form |
| dn_valid_i | input | 1 | Input sample or slot valid |
| dn_frame_i | input | 1 | Frame-start strobe for the current sample or slot |
| dn_sync_i | input | 1 | Sync pulse from the down-converter |
| dn_data_i | input | 4*DW | Down-converter lanes A to D |
| up_valid_o | output | 1 | Output sample or slot valid |
| up_frame_o | output | 1 | First slot of a replayed TDM frame |
| up_sync_o | output | 1 | Aligned sync pulse |
| up_q_phase_o | output | 1 | High when the output word is a Q component |
| up_data_o | output | 4*DW | Up-converter lanes A to D |

## Verification
The bench builds the bridge with DW=12 instead of the default 16. This shows that lane slicing, the crossed mapping and the frame buffer follow the width parameter. Running both frame lengths (4 and 8 slots) at that width reaches the slot-counter wrap for each mode. It also reaches a realignment that cuts a frame short, a gap in the middle of a frame, and configuration changes in the middle of a parallel stream and of a serial stream.

// File: rtl/iq_bridge_pkg.sv
package iq_bridge_pkg;
  localparam int unsigned NUM_PORTS = 4;
  localparam int unsigned QUAD_CH   = 4;
  localparam int unsigned MAX_SLOTS = 2 * QUAD_CH;
  localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS);

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_QUAD  = 1'b1
  } bridge_mode_e;

  // lanes swap in pairs: A<->C, B<->D
  function automatic int unsigned peer_port(input int unsigned p);
    return p ^ 2;
  endfunction

  function automatic logic [SLOT_W-1:0] last_slot(input bridge_mode_e m);
    return (m == MODE_QUAD) ? SLOT_W'(MAX_SLOTS - 1) : SLOT_W'(MAX_SLOTS / 2 - 1);
  endfunction
endpackage

// File: rtl/iq_par_path.sv
module iq_par_path
  import iq_bridge_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  quad_i,
  input  logic                  valid_i,
  input  logic                  frame_i,
  input  logic                  sync_i,
  input  logic [NUM_PORTS*DW-1:0] data_i,
  output logic                  valid_o,
  output logic                  sync_o,
  output logic                  q_o,
  output logic [NUM_PORTS*DW-1:0] data_o
);
  localparam int unsigned BUS_W = NUM_PORTS * DW;

  logic [BUS_W-1:0] crossed, s1_data, s2_data;
  logic s1_v, s2_v, s1_s, s2_s, s1_q, s2_q;
  logic ph_r, ph_now;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cross
    localparam int unsigned SRC = peer_port(p);
    assign crossed[p*DW +: DW] = data_i[SRC*DW +: DW];
  end

  assign ph_now = frame_i ? 1'b0 : ~ph_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s2_v <= 1'b0;
      s1_s <= 1'b0; s2_s <= 1'b0;
      s1_q <= 1'b0; s2_q <= 1'b0;
      ph_r <= 1'b0;
      s1_data <= '0; s2_data <= '0;
    end else begin
      s1_s <= sync_i;
      s2_s <= s1_s;
      if (flush_i) begin
        s1_v <= 1'b0;
        s2_v <= 1'b0;
      end else begin
        s1_v <= valid_i;
        s2_v <= s1_v;
      end
      if (valid_i && !flush_i) begin
        s1_data <= crossed;
        ph_r    <= ph_now;
        s1_q    <= quad_i & ph_now;
      end
      if (s1_v) begin
        s2_data <= s1_data;
        s2_q    <= s1_q;
      end
    end
  end

  assign valid_o = s2_v;
  assign sync_o  = s2_s;
  assign q_o     = s2_q;
  assign data_o  = s2_data;

  // edges seen since reset, saturating at 2
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r2_valid_two_stages: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && valid_o) |-> $past(valid_i, 2));

  a_r2_sync_two_stages: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2) |-> (sync_o == $past(sync_i, 2)));
endmodule

// File: rtl/iq_tdm_deser.sv
module iq_tdm_deser
  import iq_bridge_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    en_i,
  input  logic                    valid_i,
  input  logic                    frame_i,
  input  logic                    sync_i,
  input  logic [DW-1:0]           data_i,
  input  logic [SLOT_W-1:0]       last_i,
  output logic                    done_o,
  output logic                    sync_o,
  output logic [MAX_SLOTS*DW-1:0] slots_o
);
  logic              locked, done_q, fsync_q;
  logic [SLOT_W-1:0] cnt, idx;
  logic              take;

  assign idx  = frame_i ? '0 : cnt;
  assign take = en_i & valid_i & (frame_i | locked);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked  <= 1'b0;
      done_q  <= 1'b0;
      fsync_q <= 1'b0;
      cnt     <= '0;
      slots_o <= '0;
    end else if (flush_i) begin
      locked <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        slots_o[idx*DW +: DW] <= data_i;
        if (idx == '0) fsync_q <= sync_i;
        locked <= 1'b1;
        if (idx == last_i) begin
          cnt    <= '0;
          done_q <= 1'b1;
        end else begin
          cnt <= idx + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign sync_o = fsync_q;

  a_r6_slot_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !flush_i) |-> (cnt <= last_i));

  a_r8_unlocked_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !done_o);
endmodule

// File: rtl/iq_tdm_ser.sv
module iq_tdm_ser
  import iq_bridge_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    done_i,
  input  logic                    sync_i,
  input  logic [MAX_SLOTS*DW-1:0] slots_i,
  input  logic [SLOT_W-1:0]       last_i,
  output logic                    valid_o,
  output logic                    frame_o,
  output logic                    sync_o,
  output logic                    q_o,
  output logic [DW-1:0]           data_o
);
  logic [MAX_SLOTS*DW-1:0] hold;
  logic [SLOT_W-1:0]       cnt;
  logic                    active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold    <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      valid_o <= 1'b0;
      frame_o <= 1'b0;
      sync_o  <= 1'b0;
      q_o     <= 1'b0;
      data_o  <= '0;
    end else if (flush_i) begin
      active  <= 1'b0;
      valid_o <= 1'b0;
      frame_o <= 1'b0;
      sync_o  <= 1'b0;
    end else if (done_i) begin
      // slot 0 leaves now, the rest replay from the held copy
      hold    <= slots_i;
      data_o  <= slots_i[0 +: DW];
      valid_o <= 1'b1;
      frame_o <= 1'b1;
      sync_o  <= sync_i;
      q_o     <= 1'b1;
      cnt     <= SLOT_W'(1);
      active  <= 1'b1;
    end else if (active) begin
      data_o  <= hold[cnt*DW +: DW];
      valid_o <= 1'b1;
      frame_o <= 1'b0;
      sync_o  <= 1'b0;
      q_o     <= ~cnt[0];
      if (cnt == last_i) active <= 1'b0;
      else               cnt    <= cnt + 1'b1;
    end else begin
      valid_o <= 1'b0;
      frame_o <= 1'b0;
      sync_o  <= 1'b0;
    end
  end

  a_r5_frame_marks_q_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (valid_o && q_o));

  a_r5_sync_only_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> frame_o);

  a_r4_replay_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !flush_i) |-> (cnt <= last_i));
endmodule

// File: rtl/iq_tdm_bridge.sv
module iq_tdm_bridge
  import iq_bridge_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_i,
  input  logic                    tdm_i,
  input  logic                    dn_valid_i,
  input  logic                    dn_frame_i,
  input  logic                    dn_sync_i,
  input  logic [NUM_PORTS*DW-1:0] dn_data_i,
  output logic                    up_valid_o,
  output logic                    up_frame_o,
  output logic                    up_sync_o,
  output logic                    up_q_phase_o,
  output logic [NUM_PORTS*DW-1:0] up_data_o
);
  localparam int unsigned BUS_W = NUM_PORTS * DW;

  logic mode_q, tdm_q, chg, armed;
  logic [SLOT_W-1:0] last;

  assign chg  = (mode_i != mode_q) | (tdm_i != tdm_q);
  assign last = last_slot(bridge_mode_e'(mode_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      tdm_q  <= 1'b0;
      armed  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      tdm_q  <= tdm_i;
      if (chg)                           armed <= 1'b0;
      else if (dn_valid_i && dn_frame_i) armed <= 1'b1;
    end
  end

  // parallel path
  logic             par_in_v, par_v, par_s, par_q;
  logic [BUS_W-1:0] par_d;

  assign par_in_v = dn_valid_i & ~tdm_i & ~chg & (armed | dn_frame_i);

  iq_par_path #(.DW(DW)) u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (chg),
    .quad_i  (mode_i),
    .valid_i (par_in_v),
    .frame_i (dn_frame_i),
    .sync_i  (dn_sync_i & ~tdm_i),
    .data_i  (dn_data_i),
    .valid_o (par_v),
    .sync_o  (par_s),
    .q_o     (par_q),
    .data_o  (par_d)
  );

  // serial path: lane D in, lane A out
  logic                    des_done, des_sync;
  logic [MAX_SLOTS*DW-1:0] des_slots;
  logic                    ser_v, ser_f, ser_s, ser_q;
  logic [DW-1:0]           ser_d;

  iq_tdm_deser #(.DW(DW)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (chg),
    .en_i    (tdm_i),
    .valid_i (dn_valid_i),
    .frame_i (dn_frame_i),
    .sync_i  (dn_sync_i),
    .data_i  (dn_data_i[(NUM_PORTS-1)*DW +: DW]),
    .last_i  (last),
    .done_o  (des_done),
    .sync_o  (des_sync),
    .slots_o (des_slots)
  );

  iq_tdm_ser #(.DW(DW)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (chg),
    .done_i  (des_done),
    .sync_i  (des_sync),
    .slots_i (des_slots),
    .last_i  (last),
    .valid_o (ser_v),
    .frame_o (ser_f),
    .sync_o  (ser_s),
    .q_o     (ser_q),
    .data_o  (ser_d)
  );

  assign up_valid_o   = tdm_i ? ser_v : par_v;
  assign up_frame_o   = tdm_i & ser_f;
  assign up_sync_o    = tdm_i ? ser_s : par_s;
  assign up_q_phase_o = tdm_i ? ser_q : par_q;
  assign up_data_o    = tdm_i ? {{(BUS_W-DW){1'b0}}, ser_d} : par_d;

  a_r8_change_drops_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> !up_valid_o);

  a_r8_unarmed_par_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tdm_i && !armed && !dn_frame_i) |-> !par_in_v);
endmodule

// File: tb/iq_tdm_bridge_tb.sv
module iq_tdm_bridge_tb;
  localparam int DW    = 12;
  localparam int NP    = 4;
  localparam int BUS_W = NP * DW;
  localparam int DEPTH = 96;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b0, tdm_i = 1'b0;
  logic dn_valid_i = 1'b0, dn_frame_i = 1'b0, dn_sync_i = 1'b0;
  logic [BUS_W-1:0] dn_data_i = '0;
  logic up_valid_o, up_frame_o, up_sync_o, up_q_phase_o;
  logic [BUS_W-1:0] up_data_o;

  always #2 clk = ~clk;

  iq_tdm_bridge #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .tdm_i(tdm_i),
    .dn_valid_i(dn_valid_i), .dn_frame_i(dn_frame_i), .dn_sync_i(dn_sync_i),
    .dn_data_i(dn_data_i), .up_valid_o(up_valid_o), .up_frame_o(up_frame_o),
    .up_sync_o(up_sync_o), .up_q_phase_o(up_q_phase_o), .up_data_o(up_data_o)
  );

  int n_chk = 0, n_bad = 0;

  logic          st_v [DEPTH], st_f [DEPTH], st_s [DEPTH];
  logic [DW-1:0] st_d [DEPTH][NP];
  logic          ex_v [DEPTH], ex_f [DEPTH], ex_s [DEPTH], ex_q [DEPTH];
  logic [DW-1:0] ex_d [DEPTH][NP];

  function automatic logic [DW-1:0] pat(input int i, input int p);
    return DW'(i * 37 + p * 311 + 5);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < DEPTH; i++) begin
      st_v[i] = 0; st_f[i] = 0; st_s[i] = 0;
      ex_v[i] = 0; ex_f[i] = 0; ex_s[i] = 0; ex_q[i] = 0;
      for (int p = 0; p < NP; p++) begin st_d[i][p] = pat(i, p); ex_d[i][p] = '0; end
    end
  endtask

  task automatic drive(input int i);
    dn_valid_i = st_v[i]; dn_frame_i = st_f[i]; dn_sync_i = st_s[i];
    for (int p = 0; p < NP; p++) dn_data_i[p*DW +: DW] = st_d[i][p];
  endtask

  task automatic idle_in();
    dn_valid_i = 0; dn_frame_i = 0; dn_sync_i = 0; dn_data_i = '0;
  endtask

  // pass through another configuration so every test starts flushed and unaligned
  task automatic set_cfg(input logic m, input logic t);
    @(negedge clk); idle_in(); mode_i = ~m; tdm_i = t;
    repeat (3) @(negedge clk);
    mode_i = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic model_par(input int n, input logic quad);
    logic armed = 0, ph = 0, ph_now;
    for (int i = 0; i < n; i++) begin
      ex_s[i+2] = st_s[i];
      if (st_v[i] && (armed || st_f[i])) begin
        ph_now = st_f[i] ? 1'b0 : ~ph;
        ph = ph_now;
        ex_v[i+2] = 1;
        ex_q[i+2] = quad & ph_now;
        for (int p = 0; p < NP; p++) ex_d[i+2][p] = st_d[i][p ^ 2];
      end
      if (st_v[i] && st_f[i]) armed = 1;
    end
  endtask

  task automatic model_tdm(input int n, input int len);
    logic locked = 0, fs = 0;
    int cnt = 0, idx;
    logic [DW-1:0] buff [8];
    for (int k = 0; k < 8; k++) buff[k] = '0;
    for (int i = 0; i < n; i++) begin
      if (st_v[i] && (st_f[i] || locked)) begin
        idx = st_f[i] ? 0 : cnt;
        buff[idx] = st_d[i][3];
        if (idx == 0) fs = st_s[i];
        locked = 1;
        if (idx == len - 1) begin
          cnt = 0;
          for (int k = 0; k < len; k++) begin
            ex_v[i+2+k] = 1;
            ex_d[i+2+k][0] = buff[k];
            ex_f[i+2+k] = (k == 0);
            ex_q[i+2+k] = ((k % 2) == 0);
            ex_s[i+2+k] = (k == 0) ? fs : 1'b0;
          end
        end else cnt = idx + 1;
      end
    end
  endtask

  task automatic run(input int n, input logic tdm, input string tag);
    for (int i = 0; i < n + 12; i++) begin
      @(negedge clk);
      chk(tag, "valid", 32'(up_valid_o), 32'(ex_v[i]));
      chk(tag, "sync", 32'(up_sync_o), 32'(ex_s[i]));
      chk(tag, "frame", 32'(up_frame_o), 32'(ex_f[i]));
      if (ex_v[i]) begin
        chk(tag, "q_phase", 32'(up_q_phase_o), 32'(ex_q[i]));
        if (tdm) chk(tag, "lane A", 32'(up_data_o[0 +: DW]), 32'(ex_d[i][0]));
        else
          for (int p = 0; p < NP; p++) chk(tag, "lane", 32'(up_data_o[p*DW +: DW]), 32'(ex_d[i][p]));
      end
      if (tdm) chk({tag, " R3"}, "lanes B-D zero", 32'(|up_data_o[BUS_W-1:DW]), 32'd0);
      if (i < n) drive(i); else idle_in();
    end
  endtask

  task automatic t_reset();
    chk("R8 reset", "valid", 32'(up_valid_o), 0);
    chk("R8 reset", "sync", 32'(up_sync_o), 0);
    chk("R8 reset", "frame", 32'(up_frame_o), 0);
    chk("R8 reset", "data", 32'(|up_data_o), 0);
  endtask

  task automatic t_par_split();
    set_cfg(0, 0); clear();
    for (int i = 0; i < 10; i++) st_v[i] = 1;
    st_v[6] = 0;              // gap
    st_f[1] = 1;              // sample 0 precedes any strobe: dropped
    st_s[3] = 1; st_s[6] = 1; // sync also without valid
    model_par(10, 0);
    run(10, 0, "R1/R2/R7/R8 par split");
  endtask

  task automatic t_par_quad();
    set_cfg(1, 0); clear();
    for (int i = 0; i < 12; i++) st_v[i] = 1;
    st_v[4] = 0;
    st_f[0] = 1; st_f[7] = 1; // phase restarts on second strobe
    st_s[9] = 1;
    model_par(12, 1);
    run(12, 0, "R1/R2/R7 par quad");
  endtask

  task automatic t_tdm_split();
    set_cfg(0, 1); clear();
    for (int i = 1; i < 9; i++) st_v[i] = 1;
    st_f[1] = 1; st_f[5] = 1;
    st_s[3] = 1;              // non-first slot: ignored
    st_s[5] = 1;
    model_tdm(10, 4);
    run(10, 1, "R3/R4/R5 tdm split");
  endtask

  task automatic t_tdm_quad();
    set_cfg(1, 1); clear();
    for (int i = 1; i < 18; i++) st_v[i] = 1;
    st_v[12] = 0;             // gap inside second frame
    st_f[1] = 1; st_f[9] = 1;
    st_s[1] = 1;
    model_tdm(18, 8);
    run(18, 1, "R3/R4/R5 tdm quad");
  endtask

  task automatic t_realign();
    set_cfg(1, 1); clear();
    for (int i = 0; i < 21; i++) st_v[i] = 1;
    st_f[0] = 1; st_f[5] = 1; // first frame cut short
    st_s[13] = 1;             // wrapped frame, no strobe
    model_tdm(21, 8);
    run(21, 1, "R6 realign");
  endtask

  task automatic t_switch_par();
    set_cfg(0, 0); clear();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 2 && i <= 5) begin
        chk("R8 par switch", "valid", 32'(up_valid_o), 1);
        chk("R8 par switch", "lane A", 32'(up_data_o[0 +: DW]), 32'(pat(i - 2, 2)));
      end else if (i >= 6) chk("R8 par switch", "valid", 32'(up_valid_o), 0);
      dn_valid_i = 1; dn_frame_i = (i == 0); dn_sync_i = 0;
      for (int p = 0; p < NP; p++) dn_data_i[p*DW +: DW] = pat(i, p);
      if (i == 5) mode_i = 1;
    end
  endtask

  task automatic t_switch_tdm();
    set_cfg(1, 1); clear();
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      if (i >= 21 && i <= 24) begin
        chk("R8/R6 tdm switch", "valid", 32'(up_valid_o), 1);
        chk("R8/R6 tdm switch", "lane A", 32'(up_data_o[0 +: DW]), 32'(pat(i - 5, 3)));
        chk("R8/R6 tdm switch", "frame", 32'(up_frame_o), 32'(i == 21));
      end else chk("R8 tdm switch", "valid", 32'(up_valid_o), 0);
      dn_valid_i = (i < 20); dn_frame_i = (i == 0) || (i == 16); dn_sync_i = 0;
      for (int p = 0; p < NP; p++) dn_data_i[p*DW +: DW] = pat(i, p);
      if (i == 5) mode_i = 0;
    end
    idle_in();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_par_split();
    t_par_quad();
    t_tdm_split();
    t_tdm_quad();
    t_realign();
    t_switch_par();
    t_switch_tdm();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule